// File: doc/BRIEF.md
# Key-Locked Control Register Bank

This block is a 4 KB window of 32-bit system control registers on a simple word-addressed request/response bus. Each request is one cycle: valid, write enable, a 12-bit byte address (the low two bits are ignored), write data and byte enables. The bank never applies back-pressure, so `req_ready` is held high and every request is taken on the edge where `req_valid` is high. Read data comes back one cycle later with `rsp_valid`.

Software must first write a 16-bit unlock key to a command word before ordinary writes land. A matching lock key protects the bank again. An address map sorts each word into read-write, read-only, write-only or unmapped. Writes that are illegal, partial, or sent while the bank is locked are dropped and raise a one-cycle error pulse. An accepted write that sets bit 0 of the reset-control word raises a one-cycle soft-reset request.

Top module: `ctlbank_top`

## Requirements
- R1: After reset the bank is locked and the status word at 0x00C reads 1. Words 0x100, 0x104 and 0x108 read 0x0001A008, 0x10C reads 0x0000003F, 0x25C reads 0x00000001, and every other word reads 0.
- R2: `req_ready` is always 1. A read taken at edge k drives `rsp_valid` high with `rsp_rdata` in the cycle after edge k. `rsp_valid` is low after every other cycle.
- R3: A full-word write to 0x008 clears the lock only when data[15:0] equals 0xDF0D, whatever the upper bits hold. Any other value leaves the lock unchanged and raises no error.
- R4: A full-word write to 0x004 sets the lock only when data[15:0] equals 0x767B. Any other value leaves the lock unchanged and raises no error.
- R5: Word 0x000 can be written while locked and keeps only bit 0 of the data. Lock and unlock commands also act while locked.
- R6: While locked, a write to any other legal writable word is discarded and raises an error.
- R7: A write to a read-only word (0x00C, 0x10C, 0x25C) or to an unmapped word is discarded and raises an error. Mapped read-write words are 0x000, 0x100–0x108, 0x110–0x118, 0x120–0x16C, 0x200–0x244 and 0x700–0x7D4. Write-only words are 0x004 and 0x008.
- R8: A read of a write-only or unmapped word raises an error and still returns the stored word, which is 0 because such words are never written.
- R9: A write whose byte enable is not 4'b1111 is discarded and raises an error, even while unlocked and even for lock or unlock commands.
- R10: An accepted write to 0x200 with data bit 0 set pulses `soft_rst_req` for exactly the next cycle. The word still stores the data. A write to 0x200 that is rejected, or that has bit 0 clear, gives no pulse.
- R11: While unlocked, a full-word write to a read-write word stores all 32 bits and raises no error.
- R12: `access_err` is high for exactly the cycle after the offending request and is low after every accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_ready | output | 1 | Constant 1, no back-pressure |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address within the window |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables, must be all ones for a write |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| access_err | output | 1 | One-cycle invalid-access pulse |
| soft_rst_req | output | 1 | One-cycle soft-reset request |

## Verification
Every result of this bank is due exactly one edge after the request that caused it: read data with `rsp_valid`, the error pulse, and the soft-reset pulse. A stored write is seen on a read issued on any later cycle. The driver pushes one expected item for every cycle it drives, including idle cycles. The monitor pops one item one time unit after each rising edge, so each comparison lines up with the edge that registered the result. Effects that must not happen, such as a dropped write, a rejected key or a locked write, are checked by reading the affected word back in a following request.

// File: rtl/ctlbank_pkg.sv
package ctlbank_pkg;
  localparam int ADDR_W  = 12;
  localparam int DATA_W  = 32;
  localparam int BE_W    = DATA_W / 8;
  localparam int WIDX_W  = ADDR_W - 2;
  localparam int WORDS   = 1 << WIDX_W;
  localparam int KEY_W   = 16;

  localparam logic [KEY_W-1:0] KEY_OPEN  = 16'hDF0D;
  localparam logic [KEY_W-1:0] KEY_CLOSE = 16'h767B;

  // word indices the behaviour depends on
  localparam logic [WIDX_W-1:0] W_SCRATCH = 10'h000;
  localparam logic [WIDX_W-1:0] W_CLOSE   = 10'h001;
  localparam logic [WIDX_W-1:0] W_OPEN    = 10'h002;
  localparam logic [WIDX_W-1:0] W_LOCKST  = 10'h003;
  localparam logic [WIDX_W-1:0] W_RSTCTL  = 10'h080;

  typedef enum logic [1:0] {
    ACC_RW   = 2'd0,
    ACC_RO   = 2'd1,
    ACC_WO   = 2'd2,
    ACC_NONE = 2'd3
  } acc_e;

  function automatic acc_e classify(input logic [WIDX_W-1:0] w);
    acc_e a;
    if (w == W_CLOSE || w == W_OPEN)                 a = ACC_WO;
    else if (w == W_LOCKST || w == 10'h043 || w == 10'h097) a = ACC_RO;
    else if (w == W_SCRATCH)                         a = ACC_RW;
    else if (w inside {[10'h040:10'h042]})           a = ACC_RW;
    else if (w inside {[10'h044:10'h046]})           a = ACC_RW;
    else if (w inside {[10'h048:10'h05B]})           a = ACC_RW;
    else if (w inside {[10'h080:10'h091]})           a = ACC_RW;
    else if (w inside {[10'h1C0:10'h1F5]})           a = ACC_RW;
    else                                             a = ACC_NONE;
    return a;
  endfunction

  function automatic logic [DATA_W-1:0] init_value(input int w);
    logic [DATA_W-1:0] v;
    if (w >= 'h40 && w <= 'h42) v = 32'h0001_A008;
    else if (w == 'h43)         v = 32'h0000_003F;
    else if (w == 'h97)         v = 32'h0000_0001;
    else                        v = '0;
    return v;
  endfunction
endpackage

// File: rtl/ctlbank_access_map.sv
module ctlbank_access_map
  import ctlbank_pkg::*;
(
  input  logic [WIDX_W-1:0] word,
  output acc_e              acc
);
  always_comb acc = classify(word);
endmodule

// File: rtl/ctlbank_lock.sv
module ctlbank_lock
  import ctlbank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             close_cmd,
  input  logic             open_cmd,
  input  logic [KEY_W-1:0] key,
  output logic             locked
);
  always_ff @(posedge clk) begin
    if (!rst_n)                               locked <= 1'b1;
    else if (close_cmd && key == KEY_CLOSE)   locked <= 1'b1;
    else if (open_cmd && key == KEY_OPEN)     locked <= 1'b0;
  end
endmodule

// File: rtl/ctlbank_regfile.sv
module ctlbank_regfile
  import ctlbank_pkg::*;
#(
  parameter int N = WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [WIDX_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [WIDX_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) mem[i] <= init_value(i);
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/ctlbank_top.sv
module ctlbank_top
  import ctlbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [BE_W-1:0]   req_be,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              access_err,
  output logic              soft_rst_req
);
  logic [WIDX_W-1:0] word;
  acc_e              acc;
  logic              locked_q;
  logic              is_wr, is_rd, wr_legal, is_cmd, wr_commit;
  logic              err_d, srst_d;
  logic [DATA_W-1:0] wdata_eff, store_rd;

  assign req_ready = 1'b1;
  assign word      = req_addr[ADDR_W-1:2];
  assign is_wr     = req_valid && req_write;
  assign is_rd     = req_valid && !req_write;

  ctlbank_access_map u_map (.word(word), .acc(acc));

  always_comb begin
    wr_legal  = is_wr && (&req_be) && (acc == ACC_RW || acc == ACC_WO);
    is_cmd    = (word == W_CLOSE) || (word == W_OPEN);
    wr_commit = wr_legal && !is_cmd && (!locked_q || word == W_SCRATCH);
    wdata_eff = (word == W_SCRATCH) ? {{(DATA_W-1){1'b0}}, req_wdata[0]} : req_wdata;
    err_d     = (is_wr && (!wr_legal || (locked_q && !is_cmd && word != W_SCRATCH)))
             || (is_rd && (acc == ACC_WO || acc == ACC_NONE));
    srst_d    = wr_commit && (word == W_RSTCTL) && req_wdata[0];
  end

  ctlbank_lock u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .close_cmd(wr_legal && word == W_CLOSE),
    .open_cmd (wr_legal && word == W_OPEN),
    .key      (req_wdata[KEY_W-1:0]),
    .locked   (locked_q)
  );

  ctlbank_regfile u_rf (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (wr_commit),
    .waddr(word),
    .wdata(wdata_eff),
    .raddr(word),
    .rdata(store_rd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_rdata    <= '0;
      access_err   <= 1'b0;
      soft_rst_req <= 1'b0;
    end else begin
      rsp_valid    <= is_rd;
      access_err   <= err_d;
      soft_rst_req <= srst_d;
      if (is_rd)
        rsp_rdata <= (word == W_LOCKST) ? {{(DATA_W-1){1'b0}}, locked_q} : store_rd;
    end
  end
endmodule

// File: rtl/ctlbank_chk.sv
module ctlbank_chk
  import ctlbank_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic [BE_W-1:0]   req_be,
  input logic              rsp_valid,
  input logic              access_err,
  input logic              soft_rst_req,
  input logic              locked
);
  logic [WIDX_W-1:0] w;
  assign w = req_addr[ADDR_W-1:2];

  // R2
  rsp_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  // R10
  srst_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && w == W_RSTCTL && req_wdata[0] && (&req_be) && !locked)
      |=> soft_rst_req);

  // R6
  locked_write_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && locked && w > W_OPEN) |=> access_err);

  // R3
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write && (w == W_CLOSE || w == W_OPEN)) |=> $stable(locked));

  // R9
  partial_be_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !(&req_be)) |=> access_err);

  // R7
  ro_write_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && w == W_LOCKST) |=> access_err);
endmodule

bind ctlbank_top ctlbank_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_write   (req_write),
  .req_addr    (req_addr),
  .req_wdata   (req_wdata),
  .req_be      (req_be),
  .rsp_valid   (rsp_valid),
  .access_err  (access_err),
  .soft_rst_req(soft_rst_req),
  .locked      (locked_q)
);

// File: tb/test_ctlbank_top.sv
module test_ctlbank_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_be = '0;
  logic        req_ready, rsp_valid, access_err, soft_rst_req;
  logic [31:0] rsp_rdata;

  int vectors = 0, bad = 0;

  always #2 clk = ~clk;

  ctlbank_top i_ctlbank_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .access_err(access_err), .soft_rst_req(soft_rst_req)
  );

  typedef struct {
    logic        rv;
    logic [31:0] rd;
    logic        err;
    logic        srst;
    string       tag;
  } exp_t;
  exp_t q[$];

  task automatic put(bit rv, logic [31:0] rd, bit err, bit srst, string tag);
    exp_t e;
    e.rv = rv; e.rd = rd; e.err = err; e.srst = srst; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d, logic [3:0] be, bit eerr, bit esrst, string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_be = be;
    put(0, '0, eerr, esrst, tag);
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] exp_d, bit eerr, string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_wdata = '0; req_be = 4'hF;
    put(1, exp_d, eerr, 0, tag);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    put(0, '0, 0, 0, "R12 R2 idle");
  endtask

  // monitor: one expected item per registered cycle
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() != 0) begin
        exp_t e;
        e = q.pop_front();
        vectors++;
        if (rsp_valid !== e.rv || (e.rv && rsp_rdata !== e.rd) ||
            access_err !== e.err || soft_rst_req !== e.srst || req_ready !== 1'b1) begin
          bad++;
          $display("FAIL %s: got rv=%b rd=%h err=%b srst=%b rdy=%b, expected rv=%b rd=%h err=%b srst=%b rdy=1",
                   e.tag, rsp_valid, rsp_rdata, access_err, soft_rst_req, req_ready,
                   e.rv, e.rd, e.err, e.srst);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: got hang, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    vectors++;
    if (rsp_valid !== 1'b0 || access_err !== 1'b0 || soft_rst_req !== 1'b0) begin
      bad++;
      $display("FAIL R1 outputs after reset: got %b%b%b expected 000", rsp_valid, access_err, soft_rst_req);
    end
    // R1 reset contents
    rd(12'h00C, 32'h1, 0, "R1 lock status");
    rd(12'h100, 32'h0001A008, 0, "R1 0x100");
    rd(12'h104, 32'h0001A008, 0, "R1 0x104");
    rd(12'h108, 32'h0001A008, 0, "R1 0x108");
    rd(12'h10C, 32'h3F, 0, "R1 0x10C");
    rd(12'h25C, 32'h1, 0, "R1 0x25C");
    rd(12'h120, 32'h0, 0, "R1 0x120");
    idle();
    // R6 locked write dropped
    wr(12'h120, 32'hCAFEF00D, 4'hF, 1, 0, "R6 locked write");
    rd(12'h120, 32'h0, 0, "R6 readback");
    wr(12'h200, 32'h1, 4'hF, 1, 0, "R10 R6 locked reset write");
    rd(12'h200, 32'h0, 0, "R10 locked reset readback");
    // R5 scratch word
    wr(12'h000, 32'hFFFFFFFE, 4'hF, 0, 0, "R5 scratch bit0 clear");
    rd(12'h000, 32'h0, 0, "R5 readback 0");
    wr(12'h000, 32'hFFFFFFFF, 4'hF, 0, 0, "R5 scratch while locked");
    rd(12'h000, 32'h1, 0, "R5 readback 1");
    // R3 unlock
    wr(12'h008, 32'h00001234, 4'hF, 0, 0, "R3 wrong key");
    rd(12'h00C, 32'h1, 0, "R3 still locked");
    wr(12'h008, 32'hABCDDF0D, 4'h7, 1, 0, "R9 partial unlock");
    rd(12'h00C, 32'h1, 0, "R9 still locked");
    wr(12'h008, 32'hABCDDF0D, 4'hF, 0, 0, "R3 good key");
    rd(12'h00C, 32'h0, 0, "R3 unlocked");
    // R11 writes land
    wr(12'h120, 32'hCAFEF00D, 4'hF, 0, 0, "R11 write");
    rd(12'h120, 32'hCAFEF00D, 0, "R11 readback");
    wr(12'h7D4, 32'h12345678, 4'hF, 0, 0, "R11 last mapped");
    rd(12'h7D4, 32'h12345678, 0, "R11 last readback");
    // R9 partial write
    wr(12'h120, 32'h0, 4'hE, 1, 0, "R9 partial write");
    rd(12'h120, 32'hCAFEF00D, 0, "R9 unchanged");
    // R7 read-only and unmapped
    wr(12'h10C, 32'h0, 4'hF, 1, 0, "R7 ro write");
    rd(12'h10C, 32'h3F, 0, "R7 ro unchanged");
    wr(12'h25C, 32'h5, 4'hF, 1, 0, "R7 boot write");
    rd(12'h25C, 32'h1, 0, "R7 boot unchanged");
    wr(12'h7D8, 32'hFFFF, 4'hF, 1, 0, "R7 unmapped write");
    // R8 invalid reads
    rd(12'h7D8, 32'h0, 1, "R8 unmapped read");
    rd(12'h004, 32'h0, 1, "R8 wo read 0x004");
    rd(12'h008, 32'h0, 1, "R8 wo read 0x008");
    // R10 soft reset
    wr(12'h200, 32'h1, 4'hF, 0, 1, "R10 pulse");
    idle();
    rd(12'h200, 32'h1, 0, "R10 stored");
    wr(12'h200, 32'h2, 4'hF, 0, 0, "R10 bit0 clear");
    rd(12'h200, 32'h2, 0, "R10 stored 2");
    // R4 lock
    wr(12'h004, 32'h0000767C, 4'hF, 0, 0, "R4 wrong key");
    rd(12'h00C, 32'h0, 0, "R4 still open");
    wr(12'h004, 32'hFFFF767B, 4'hF, 0, 0, "R4 good key");
    rd(12'h00C, 32'h1, 0, "R4 locked");
    wr(12'h124, 32'h77, 4'hF, 1, 0, "R6 relocked write");
    rd(12'h124, 32'h0, 0, "R6 relocked readback");
    wr(12'h00C, 32'h0, 4'hF, 1, 0, "R7 status write");
    rd(12'h00C, 32'h1, 0, "R7 status unchanged");
    // R12 back-to-back errors then clean
    wr(12'hFFC, 32'h0, 4'hF, 1, 0, "R12 err a");
    wr(12'hFFC, 32'h0, 4'hF, 1, 0, "R12 err b");
    idle();
    idle();
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
    $finish;
  end
endmodule